// File: doc/BRIEF.md
# Video RAM Transfer Cycle Controller

This block sequences one shift-register transfer cycle of a video RAM. A system arbiter raises an advance request some clock periods before a transfer is due. The controller answers with a hold-off output, so that the arbiter stops granting new accesses and refreshes and lets any running cycle finish. When the load input then rises, the transfer-enable/output-enable strobe (DT/OE, active low) falls at once, combinationally, with no wait for a clock edge. RAS and then CAS follow on later rising edges.

A transfer ends in one of two ways, whichever happens first. Either the load input falls, or the clock reaches a fixed number of rising edges after the load input rose (four by default). DT/OE then returns high. RAS and CAS are released on the next edge. If the load input is still high when the cycle ends, the controller will not start a new transfer until the load input has gone low. If a load arrives without the advance request, the controller performs the transfer anyway and reports a protocol error.

Top module: `vram_xfer_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `dt_oe_n`, `ras_n` and `cas_n` are high and `busy` and `proto_err` are low.
- R2: When `load` rises while the controller is idle and armed, `dt_oe_n` goes low in the same cycle, before any clock edge, and `ras_n` is still high at that point.
- R3: `ras_n` goes low on the first rising edge at which `load` is sampled high while idle. `cas_n` goes low CAS_DELAY edges later (1 by default), provided `load` is still high at that edge.
- R4: If `load` stays high, `dt_oe_n` returns high right after the LOAD_EDGES-th rising edge (4 by default), counted from the edge that asserted RAS.
- R5: If `load` falls before that edge, `dt_oe_n` returns high at once, combinationally, and the transfer ends early.
- R6: `ras_n` and `cas_n` return high on the first rising edge after `dt_oe_n` has returned high.
- R7: After a transfer ends with `load` still high, `dt_oe_n` and `ras_n` stay high until `load` has been seen low at a rising edge.
- R8: `hold` is high whenever `adv_req` is high or a transfer is active (`busy` high).
- R9: `busy` is high while `dt_oe_n` is low or while RAS is held for a transfer, and low otherwise.
- R10: If a transfer starts at an edge where `adv_req` is low, `proto_err` is high for exactly the following cycle, and the transfer still takes place. A transfer started with `adv_req` high leaves `proto_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_req | input | 1 | Advance notice that a transfer is coming |
| load | input | 1 | Shift-register load request, active high |
| dt_oe_n | output | 1 | Transfer/output-enable strobe, active low, driven combinationally from `load` |
| ras_n | output | 1 | Row strobe for the transfer, active low |
| cas_n | output | 1 | Column strobe for the transfer, active low |
| hold | output | 1 | Tells the arbiter to hold off new accesses and refreshes |
| busy | output | 1 | A transfer cycle is active |
| proto_err | output | 1 | A load arrived without an advance request |

## Verification
The embedded assertions check on every cycle that CAS is never active without RAS, that RAS never starts unless `load` was high, that the edge counter stays inside its window, that both strobes drop on the edge after a release, that the controller stays disarmed while it waits for `load` to fall, and that `hold` follows `adv_req`. Only the bench scenarios can show the exact cycle in which each strobe moves. They also show which of the two termination conditions wins the race, that DT/OE falls before a clock edge arrives, and that a `load` held past the end of a cycle does not start a second transfer. The bench model predicts every output each cycle, across full-length, truncated, held-over and unannounced transfers.

// File: rtl/vram_xfer_pkg.sv
package vram_xfer_pkg;
   typedef enum logic [1:0] {
      XS_IDLE  = 2'd0,
      XS_XFER  = 2'd1,
      XS_TAIL  = 2'd2,
      XS_REARM = 2'd3
   } xfer_state_e;
endpackage

// File: rtl/xfer_seq.sv
module xfer_seq
   import vram_xfer_pkg::*;
#(
   parameter int LOAD_EDGES = 4,
   parameter int CAS_DELAY  = 1,
   parameter int CNT_W      = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_i,
   output xfer_state_e state_o,
   output logic        start_o,
   output logic        cas_set_o,
   output logic        release_o,
   output logic        dt_low_o
);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LOAD_EDGES - 1);
   localparam logic [CNT_W-1:0] CAS_CNT  = CNT_W'(CAS_DELAY);

   xfer_state_e       state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              in_xfer;

   assign in_xfer   = (state_q == XS_XFER);
   assign start_o   = (state_q == XS_IDLE) && load_i;
   assign cas_set_o = in_xfer && load_i && (cnt_q == CAS_CNT);
   assign release_o = (in_xfer && !load_i) || (state_q == XS_TAIL);
   assign dt_low_o  = load_i && ((state_q == XS_IDLE) || in_xfer);
   assign state_o   = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            XS_IDLE: begin
               if (load_i) begin
                  state_q <= XS_XFER;
                  cnt_q   <= CNT_W'(1);
               end
            end
            XS_XFER: begin
               if (!load_i) begin
                  state_q <= XS_IDLE;
                  cnt_q   <= '0;
               end else if (cnt_q == LAST_CNT) begin
                  state_q <= XS_TAIL;
                  cnt_q   <= '0;
               end else begin
                  cnt_q   <= cnt_q + CNT_W'(1);
               end
            end
            XS_TAIL: begin
               state_q <= load_i ? XS_REARM : XS_IDLE;
            end
            XS_REARM: begin
               if (!load_i) state_q <= XS_IDLE;
            end
            default: state_q <= XS_IDLE;
         endcase
      end
   end

   AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == XS_XFER) |-> (cnt_q >= CNT_W'(1)) && (cnt_q <= LAST_CNT)); // R4

   AST_TAIL_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == XS_TAIL) |-> $past(load_i) && ($past(cnt_q) == LAST_CNT)); // R4

   AST_REARM_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == XS_REARM) |-> !dt_low_o && !start_o); // R7
endmodule

// File: rtl/xfer_strobe.sv
module xfer_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic cas_set_i,
   input  logic release_i,
   output logic ras_o,
   output logic cas_o
);
   logic ras_q, cas_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q <= 1'b0;
         cas_q <= 1'b0;
      end else begin
         if (release_i) begin
            ras_q <= 1'b0;
            cas_q <= 1'b0;
         end else begin
            if (start_i)   ras_q <= 1'b1;
            if (cas_set_i) cas_q <= 1'b1;
         end
      end
   end

   assign ras_o = ras_q;
   assign cas_o = cas_q;

   AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      cas_q |-> ras_q); // R3

   AST_CAS_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_q) |-> $past(ras_q)); // R3

   AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      release_i |=> !ras_q && !cas_q); // R6
endmodule

// File: rtl/xfer_err.sv
module xfer_err #(
   parameter bit STICKY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic adv_i,
   output logic err_o
);
   logic err_q;

   generate
      if (STICKY) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       err_q <= 1'b0;
            else if (start_i) err_q <= !adv_i;
         end
      end else begin : g_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= start_i && !adv_i;
         end

         AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            err_q |-> $past(start_i) && !$past(adv_i)); // R10

         AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            err_q |=> !err_q); // R10
      end
   endgenerate

   assign err_o = err_q;
endmodule

// File: rtl/vram_xfer_ctrl.sv
module vram_xfer_ctrl
   import vram_xfer_pkg::*;
#(
   parameter int LOAD_EDGES = 4,
   parameter int CAS_DELAY  = 1,
   parameter bit ERR_STICKY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv_req,
   input  logic load,
   output logic dt_oe_n,
   output logic ras_n,
   output logic cas_n,
   output logic hold,
   output logic busy,
   output logic proto_err
);
   localparam int CNT_W = $clog2(LOAD_EDGES + 1);

   generate
      if (LOAD_EDGES < 2) begin : g_bad_edges
         $error("LOAD_EDGES must be at least 2");
      end
      if (CAS_DELAY < 1 || CAS_DELAY >= LOAD_EDGES) begin : g_bad_cas
         $error("CAS_DELAY must lie in 1..LOAD_EDGES-1");
      end
   endgenerate

   xfer_state_e state;
   logic start, cas_set, release_ev, dt_low;
   logic ras_a, cas_a;

   xfer_seq #(
      .LOAD_EDGES(LOAD_EDGES),
      .CAS_DELAY (CAS_DELAY),
      .CNT_W     (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .state_o  (state),
      .start_o  (start),
      .cas_set_o(cas_set),
      .release_o(release_ev),
      .dt_low_o (dt_low)
   );

   xfer_strobe u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .cas_set_i(cas_set),
      .release_i(release_ev),
      .ras_o    (ras_a),
      .cas_o    (cas_a)
   );

   xfer_err #(.STICKY(ERR_STICKY)) u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .adv_i  (adv_req),
      .err_o  (proto_err)
   );

   assign dt_oe_n = !dt_low;
   assign ras_n   = !ras_a;
   assign cas_n   = !cas_a;
   assign busy    = dt_low || (state == XS_XFER) || (state == XS_TAIL);
   assign hold    = adv_req || busy;

   AST_HOLD_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      adv_req |-> hold); // R8

   AST_RAS_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_a) |-> $past(load)); // R2

   AST_RAS_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ras_a |-> busy); // R9
endmodule

// File: tb/vram_xfer_ctrl_tb.sv
module vram_xfer_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic adv_req = 1'b0;
   logic load = 1'b0;
   logic dt_oe_n, ras_n, cas_n, hold, busy, proto_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit compare_on = 1'b0;

   // behavioural model state
   bit m_active, m_tail, m_wait_low, m_ras, m_cas, m_err;
   int m_edges;

   always #10 clk = ~clk;

   vram_xfer_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .adv_req(adv_req), .load(load),
      .dt_oe_n(dt_oe_n), .ras_n(ras_n), .cas_n(cas_n),
      .hold(hold), .busy(busy), .proto_err(proto_err)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   // model advances on each rising edge from the inputs sampled there
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_active = 0; m_tail = 0; m_wait_low = 0;
         m_ras = 0; m_cas = 0; m_err = 0; m_edges = 0;
      end else begin
         m_err = 0;
         if (m_active) begin
            if (!load) begin
               m_active = 0; m_ras = 0; m_cas = 0;
            end else begin
               m_edges = m_edges + 1;
               if (m_edges == 2) m_cas = 1;
               if (m_edges == 4) begin m_active = 0; m_tail = 1; end
            end
         end else if (m_tail) begin
            m_tail = 0; m_ras = 0; m_cas = 0; m_wait_low = load;
         end else if (m_wait_low) begin
            if (!load) m_wait_low = 0;
         end else if (load) begin
            m_active = 1; m_edges = 1; m_ras = 1; m_cas = 0; m_err = !adv_req;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && compare_on && !done) begin
         logic exp_dt, exp_busy;
         exp_dt   = load && !m_tail && !m_wait_low;
         exp_busy = exp_dt || m_active || m_tail;
         chk("R2/R4/R5 dt_oe_n", dt_oe_n, !exp_dt);
         chk("R3/R6 ras_n", ras_n, !m_ras);
         chk("R3/R6 cas_n", cas_n, !m_cas);
         chk("R9 busy", busy, exp_busy);
         chk("R8 hold", hold, adv_req || exp_busy);
         chk("R10 proto_err", proto_err, m_err);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   initial begin
      #5;
      chk("R1 dt_oe_n in reset", dt_oe_n, 1'b1);
      chk("R1 ras_n in reset", ras_n, 1'b1);
      chk("R1 cas_n in reset", cas_n, 1'b1);
      chk("R1 busy in reset", busy, 1'b0);
      chk("R1 proto_err in reset", proto_err, 1'b0);
      step(2);
      rst_n = 1'b1;
      compare_on = 1'b1;
      step(2);

      // full-length transfer, announced
      adv_req = 1'b1;
      step(3);
      load = 1'b1;
      #1;
      chk("R2 dt_oe_n low before edge", dt_oe_n, 1'b0);
      chk("R2 ras_n still high", ras_n, 1'b1);
      step(1);
      chk("R3 ras_n low after first edge", ras_n, 1'b0);
      chk("R3 cas_n high after first edge", cas_n, 1'b1);
      step(1);
      chk("R3 cas_n low after second edge", cas_n, 1'b0);
      step(2);
      chk("R4 dt_oe_n released after fourth edge", dt_oe_n, 1'b1);
      chk("R6 ras_n held in tail", ras_n, 1'b0);
      load = 1'b0;
      step(1);
      chk("R6 ras_n released", ras_n, 1'b1);
      chk("R6 cas_n released", cas_n, 1'b1);
      adv_req = 1'b0;
      step(3);

      // early termination after two edges
      adv_req = 1'b1;
      step(2);
      load = 1'b1;
      step(2);
      load = 1'b0;
      #1;
      chk("R5 dt_oe_n released on load fall", dt_oe_n, 1'b1);
      chk("R5 ras_n still held", ras_n, 1'b0);
      step(1);
      chk("R6 ras_n released after early end", ras_n, 1'b1);
      adv_req = 1'b0;
      step(3);

      // very short load: dropped before CAS
      adv_req = 1'b1;
      load = 1'b1;
      step(1);
      load = 1'b0;
      step(1);
      chk("R5 cas_n never asserted on short load", cas_n, 1'b1);
      adv_req = 1'b0;
      step(2);

      // load held past the end: no second transfer
      adv_req = 1'b1;
      load = 1'b1;
      step(8);
      chk("R7 dt_oe_n stays high while load held", dt_oe_n, 1'b1);
      chk("R7 ras_n stays high while load held", ras_n, 1'b1);
      adv_req = 1'b0;
      load = 1'b0;
      step(2);

      // unannounced transfer
      load = 1'b1;
      step(1);
      chk("R10 proto_err raised", proto_err, 1'b1);
      chk("R10 transfer still runs", ras_n, 1'b0);
      step(1);
      chk("R10 proto_err one cycle only", proto_err, 1'b0);
      step(3);
      load = 1'b0;
      step(3);

      // hold follows advance request while idle
      adv_req = 1'b1;
      #1;
      chk("R8 hold with advance request", hold, 1'b1);
      step(1);
      adv_req = 1'b0;
      #1;
      chk("R8 hold drops when idle", hold, 1'b0);
      step(2);

      // back-to-back transfers
      adv_req = 1'b1;
      for (int k = 0; k < 3; k++) begin
         load = 1'b1;
         step(2 + k);
         load = 1'b0;
         step(1);
      end
      adv_req = 1'b0;
      step(4);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule